// File: doc/BRIEF.md
# Real-Mode Address Generator With Wrap Gate

This block turns a 16-bit segment and a 16-bit offset into a physical byte address. It shifts the segment left by four bits and adds the offset. The sum can reach 21 bits. A gate register controls bit 20 of the sum before it reaches a 24-bit address bus. When the gate is closed, bit 20 is forced to zero. Any sum above 0xFFFFF then folds back to low memory, which is the classic one-megabyte wraparound. When the gate is open, the full sum reaches the bus.

The gate is programmed through a deliberately slow sideband port. A write is accepted and then held pending for a fixed number of cycles, set by a parameter. A busy flag stays high during that time. Requests made while a change is pending still use the old gate setting. The address output is registered and is qualified by a valid flag one cycle after each request.

Top module: `rm_addr_gen`

## Requirements
- R1: With the gate closed, `phys_addr` equals (seg·16 + off) modulo 2^20, so carries beyond 0xFFFFF wrap to low addresses.
- R2: With the gate open, `phys_addr` equals the full sum seg·16 + off, including bit 20.
- R3: Bits 23:21 of `phys_addr` are zero at all times.
- R4: `addr_vld` is high in exactly the cycle after a cycle with `req` high. `phys_addr` is updated only on a request and holds its value otherwise.
- R5: After reset the gate is closed, `gate_busy` is low, `addr_vld` is low and `phys_addr` is zero.
- R6: When a gate write (`gate_wr` high, value `gate_val`, 1 = open) is sampled with `gate_busy` low, `gate_busy` is high for exactly GATE_LAT cycles after that edge. The new value then governs every request sampled after `gate_busy` falls.
- R7: A request sampled while `gate_busy` is high uses the gate value that was in force before the write.
- R8: A gate write sampled while `gate_busy` is high is ignored. It neither changes the pending value nor extends the busy time.
- R9: With segment 0xFF00 and the gate closed, offset 0x0FFF gives 0xFFFFF and offset 0x1000 gives 0x00000. With the gate open, offset 0x1000 gives 0x100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Address request strobe |
| seg | input | 16 | Segment value |
| off | input | 16 | Offset value |
| gate_wr | input | 1 | Gate register write strobe |
| gate_val | input | 1 | Gate value to write (1 = pass bit 20) |
| gate_busy | output | 1 | A gate change is pending |
| phys_addr | output | 24 | Registered physical address |
| addr_vld | output | 1 | phys_addr was loaded by the previous request |

## Verification
A gate register that holds the wrong value shows up only on requests whose sum carries into bit 20. The bench therefore aims segments near the top of memory at each gate state, and the error appears on the first such address, one cycle after the request. A delay counter that is off by one shows immediately as `gate_busy` falling a cycle early or late. It also shows as a carry request issued right at the boundary that resolves with the wrong gate. Damage to the pending value shows only when the write completes, so each write is followed by a carry probe.

// File: rtl/rm_pkg.sv
package rm_pkg;
   typedef enum logic {
      GATE_WRAP = 1'b0,
      GATE_PASS = 1'b1
   } gate_mode_e;

   function automatic int sum_width(input int seg_w, input int off_w, input int shamt);
      int a;
      a = seg_w + shamt;
      return ((a > off_w) ? a : off_w) + 1;
   endfunction
endpackage

// File: rtl/rm_lin_sum.sv
module rm_lin_sum #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHAMT = 4,
   localparam int SUM_W = rm_pkg::sum_width(SEG_W, OFF_W, SHAMT)
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   output logic [SUM_W-1:0] sum
);
   logic [SUM_W-1:0] seg_sh;
   logic [SUM_W-1:0] off_ext;

   assign seg_sh  = SUM_W'({seg, {SHAMT{1'b0}}});
   assign off_ext = SUM_W'(off);
   assign sum     = seg_sh + off_ext;
endmodule

// File: rtl/rm_gate_ctl.sv
module rm_gate_ctl #(
   parameter int GATE_LAT = 8,
   localparam int CNT_W = $clog2(GATE_LAT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic val,
   output logic gate,
   output logic busy
);
   import rm_pkg::*;

   gate_mode_e       gate_q;
   logic             pend_q;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   initial assert (GATE_LAT >= 1) else $error("GATE_LAT must be at least 1");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= GATE_WRAP;
         pend_q <= 1'b0;
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (wr) begin
            pend_q <= val;
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(GATE_LAT);
         end
      end else if (cnt_q == CNT_W'(1)) begin
         gate_q <= gate_mode_e'(pend_q);
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign gate = gate_q;
   assign busy = busy_q;

   assert_busy_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(wr));
   assert_gate_moves_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_q) |-> $fell(busy_q));
   assert_busy_never_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q != '0));
   assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && wr) |=> $stable(pend_q));
endmodule

// File: rtl/rm_addr_reg.sv
module rm_addr_reg #(
   parameter int SUM_W    = 21,
   parameter int BUS_W    = 24,
   parameter int GATE_BIT = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [SUM_W-1:0] sum,
   input  logic             gate,
   output logic [BUS_W-1:0] addr,
   output logic             vld
);
   logic [BUS_W-1:0] gated;

   initial assert (BUS_W >= SUM_W) else $error("BUS_W narrower than sum");
   initial assert (GATE_BIT < SUM_W) else $error("GATE_BIT outside sum");

   for (genvar b = 0; b < BUS_W; b++) begin : g_bit
      if (b == GATE_BIT) begin : g_gate
         assign gated[b] = sum[b] & gate;
      end else if (b < SUM_W) begin : g_pass
         assign gated[b] = sum[b];
      end else begin : g_pad
         assign gated[b] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         vld  <= 1'b0;
      end else begin
         vld <= req;
         if (req) addr <= gated;
      end
   end

   assert_vld_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> vld);
   assert_no_vld_without_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !vld);
   assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> $stable(addr));
   assert_wrap_when_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !gate) |=> !addr[GATE_BIT]);

   if (BUS_W > SUM_W) begin : g_chk_upper
      assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
         addr[BUS_W-1:SUM_W] == '0);
   end
endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen #(
   parameter int SEG_W    = 16,
   parameter int OFF_W    = 16,
   parameter int SHAMT    = 4,
   parameter int BUS_W    = 24,
   parameter int GATE_BIT = 20,
   parameter int GATE_LAT = 8,
   localparam int SUM_W   = rm_pkg::sum_width(SEG_W, OFF_W, SHAMT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   input  logic             gate_wr,
   input  logic             gate_val,
   output logic             gate_busy,
   output logic [BUS_W-1:0] phys_addr,
   output logic             addr_vld
);
   logic [SUM_W-1:0] lin_sum;
   logic             gate_now;

   rm_lin_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHAMT(SHAMT)) u_sum (
      .seg (seg),
      .off (off),
      .sum (lin_sum)
   );

   rm_gate_ctl #(.GATE_LAT(GATE_LAT)) u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (gate_wr),
      .val  (gate_val),
      .gate (gate_now),
      .busy (gate_busy)
   );

   rm_addr_reg #(.SUM_W(SUM_W), .BUS_W(BUS_W), .GATE_BIT(GATE_BIT)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req),
      .sum  (lin_sum),
      .gate (gate_now),
      .addr (phys_addr),
      .vld  (addr_vld)
   );

   assert_reset_quiet_R5: assert property (@(posedge clk)
      !rst_n |=> (!gate_busy && !addr_vld && phys_addr == '0));
endmodule

// File: tb/sim_rm_addr_gen.sv
`timescale 1ns/1ps
module sim_rm_addr_gen;
   localparam int LAT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [15:0] seg = '0;
   logic [15:0] off = '0;
   logic        gate_wr = 1'b0;
   logic        gate_val = 1'b0;
   logic        gate_busy;
   logic [23:0] phys_addr;
   logic        addr_vld;

   int checks = 0;
   int fails = 0;
   logic g_model = 1'b0;

   always #2.5 clk = ~clk;

   rm_addr_gen #(.GATE_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .seg(seg), .off(off),
      .gate_wr(gate_wr), .gate_val(gate_val), .gate_busy(gate_busy),
      .phys_addr(phys_addr), .addr_vld(addr_vld)
   );

   function automatic logic [23:0] exp_addr(input logic [15:0] s, input logic [15:0] o,
                                            input logic g);
      logic [23:0] t;
      t = {4'h0, s, 4'h0} + {8'h0, o};
      if (!g) t[20] = 1'b0;
      return t;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_req(input string tag, input logic [15:0] s, input logic [15:0] o,
                         input logic g);
      @(negedge clk);
      req = 1'b1; seg = s; off = o;
      @(negedge clk);
      req = 1'b0;
      check({tag, " vld R4"}, 32'(addr_vld), 32'd1);
      check({tag, " addr"}, 32'(phys_addr), 32'(exp_addr(s, o, g)));
      check({tag, " upper R3"}, 32'(phys_addr[23:21]), 32'd0);
   endtask

   task automatic start_write(input logic v);
      @(negedge clk);
      gate_wr = 1'b1; gate_val = v;
      @(negedge clk);
      gate_wr = 1'b0;
   endtask

   task automatic wait_idle();
      while (gate_busy) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("reset busy R5", 32'(gate_busy), 32'd0);
      check("reset vld R5", 32'(addr_vld), 32'd0);
      check("reset addr R5", 32'(phys_addr), 32'd0);
      do_req("reset gate closed R5", 16'hFFFF, 16'h0010, 1'b0);

      do_req("R9 top of ROM", 16'hFF00, 16'h0FFF, 1'b0);
      do_req("R9 wrap to zero", 16'hFF00, 16'h1000, 1'b0);
      do_req("R1 wrap max", 16'hFFFF, 16'hFFFF, 1'b0);
      do_req("R1 low", 16'h1234, 16'h5678, 1'b0);

      @(negedge clk);
      check("idle vld R4", 32'(addr_vld), 32'd0);
      check("idle hold R4", 32'(phys_addr), 32'(exp_addr(16'h1234, 16'h5678, 1'b0)));

      // R6: busy window length, R8: second write ignored
      @(negedge clk);
      gate_wr = 1'b1; gate_val = 1'b1;
      @(negedge clk);
      gate_val = 1'b0;
      check("R6 busy first", 32'(gate_busy), 32'd1);
      @(negedge clk);
      gate_wr = 1'b0;
      check("R6 busy 2", 32'(gate_busy), 32'd1);
      for (int i = 3; i <= LAT; i++) begin
         @(negedge clk);
         check("R6 busy hold", 32'(gate_busy), 32'd1);
      end
      @(negedge clk);
      check("R6 R8 busy falls on time", 32'(gate_busy), 32'd0);
      g_model = 1'b1;
      do_req("R8 pending kept open", 16'hFF00, 16'h1000, 1'b1);
      do_req("R9 open no wrap", 16'hFF00, 16'h1000, 1'b1);
      do_req("R2 open max", 16'hFFFF, 16'hFFFF, 1'b1);

      // R7: request during busy uses old gate
      start_write(1'b0);
      do_req("R7 during busy old open", 16'hFFFF, 16'h0010, 1'b1);
      wait_idle();
      g_model = 1'b0;
      do_req("R6 new closed", 16'hFFFF, 16'h0010, 1'b0);

      // R7: last cycle of busy still old gate
      start_write(1'b1);
      repeat (LAT - 2) @(negedge clk);
      req = 1'b1; seg = 16'hFFFF; off = 16'h0020;
      @(negedge clk);
      req = 1'b0;
      check("R7 boundary old closed", 32'(phys_addr), 32'(exp_addr(16'hFFFF, 16'h0020, 1'b0)));
      wait_idle();
      g_model = 1'b1;
      do_req("R6 boundary new open", 16'hFFFF, 16'h0020, 1'b1);

      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [15:0] rs;
         logic [15:0] ro;
         rs = 16'($urandom);
         ro = 16'($urandom);
         if (n % 4 == 0) rs[15:12] = 4'hF;
         if (n % 37 == 36) begin
            start_write(~g_model);
            wait_idle();
            g_model = ~g_model;
         end
         do_req(g_model ? "R2 random" : "R1 random", rs, ro, g_model);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule